// File: doc/BRIEF.md
# Flash Command Register Sequencer

This block is the command front end of a flash controller. Software places a command number in a command register. The block drops its ready flag on the next cycle and then holds the command until the host bus interface shows an idle cycle. At the first edge where the bus is idle, it sends a one-cycle launch pulse, carrying the command code, to the execution engine. When the engine reports that it has finished, the ready flag rises again. Until then, reads from flash and writes to the page buffer have to wait.

A control register holds one interrupt enable bit. When a command completes with the enable set, a level interrupt asserts. It stays asserted while the flag and the enable remain set, and it drops when a new command is accepted. The quick page read command (code 0x0C) never raises the interrupt. A command written while the block is busy is discarded, and a sticky error bit records it. A status read clears that bit. In this block, the execution engine is a stub that reports completion a fixed number of cycles after launch.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, ready_o is 1, irq_o is 0, launch_o is 0, the interrupt enable is 0 and stat_o is 0x0001 (only the ready bit set).
- R2: A cmd_wr_i pulse while ready_o is 1 is accepted. In the next cycle ready_o is 0, irq_o is 0 and stat_o bits [8+:CMD_W] hold the written code.
- R3: launch_o stays 0 while bus_idle_i is sampled low. It pulses for exactly one cycle after the first edge, following the accepting edge, at which bus_idle_i is high, and launch_code_o then equals the accepted code.
- R4: ready_o returns to 1 exactly EXEC_CYCLES+2 cycles after the cycle in which launch_o was 1. Bus activity after launch has no effect on this.
- R5: The status word places ready at bit 0, the command error at bit 1, "waiting for idle bus" at bit 2, "executing" at bit 3 and the last accepted code at bits [8+:CMD_W]. All other bits read 0.
- R6: A cmd_wr_i pulse while ready_o is 0 is ignored: the stored code, the launch count and the ready timing are unchanged. It sets the error bit (bit 1) in the next cycle.
- R7: A stat_rd_i pulse clears the error bit in the next cycle. If an ignored write occurs in the same cycle, the bit stays set.
- R8: irq_o is 1 exactly when ready_o is 1, the enable is 1, at least one command has completed since reset and the last code is not 0x0C. It rises in the same cycle as ready_o.
- R9: Completion of code 0x0C never raises irq_o, whatever the enable bit.
- R10: irq_o falls in the cycle after an accepted command write.
- R11: ctrl_wr_i loads ctrl_irq_en_i into the enable bit. Clearing the enable drops irq_o in the next cycle, and setting it after a non-0x0C completion raises irq_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_code_i | input | CMD_W | Command number written |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_irq_en_i | input | 1 | Interrupt enable value written |
| stat_rd_i | input | 1 | Status register read strobe (clears error) |
| bus_idle_i | input | 1 | Host bus interface idle in this cycle |
| ready_o | output | 1 | Ready flag |
| irq_o | output | 1 | Completion interrupt, level |
| stat_o | output | 8+CMD_W | Status word |
| launch_o | output | 1 | One-cycle command start to the engine |
| launch_code_o | output | CMD_W | Code of the launched command |

## Verification
The assertions assume that the strobes are clean single-bit levels sampled at the clock edge, and that cmd_code_i is stable whenever cmd_wr_i is high. They make no assumption about how long the bus stays busy. The bench drives every input at the falling edge from a fixed-seed random source. It holds the bus busy for a random 0 to 5 cycles before launch, toggles bus_idle_i at random during execution, and injects writes while busy. The quick page read code is chosen often enough that its interrupt suppression is tested with the enable both set and clear.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2
    } seq_st_e;

    localparam int STAT_READY_BIT = 0;
    localparam int STAT_ERR_BIT   = 1;
    localparam int STAT_WAIT_BIT  = 2;
    localparam int STAT_EXEC_BIT  = 3;
    localparam int STAT_CODE_LSB  = 8;
endpackage

// File: rtl/fcs_exec_stub.sv
module fcs_exec_stub #(
    parameter int EXEC_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);
    localparam int CNT_W = $clog2(EXEC_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } stub_t;

    stub_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_W'(EXEC_CYCLES);
        end else if (s_q.busy) begin
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o = s_q.done;
endmodule

// File: rtl/fcs_seq_core.sv
module fcs_seq_core
    import fcs_pkg::*;
#(
    parameter int CMD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr_i,
    input  logic [CMD_W-1:0] cmd_code_i,
    input  logic             stat_rd_i,
    input  logic             bus_idle_i,
    input  logic             eng_done_i,
    output logic             ready_o,
    output logic             err_o,
    output logic             waiting_o,
    output logic             executing_o,
    output logic             launch_o,
    output logic             cmpl_o,
    output logic [CMD_W-1:0] code_o
);
    typedef struct packed {
        seq_st_e          st;
        logic             ready;
        logic             err;
        logic             launch;
        logic             cmpl;
        logic [CMD_W-1:0] code;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d        = c_q;
        c_d.launch = 1'b0;
        if (stat_rd_i) c_d.err = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (cmd_wr_i) begin
                    c_d.st    = ST_WAIT;
                    c_d.ready = 1'b0;
                    c_d.cmpl  = 1'b0;
                    c_d.code  = cmd_code_i;
                end
            end
            ST_WAIT: begin
                if (cmd_wr_i) c_d.err = 1'b1;
                if (bus_idle_i) begin
                    c_d.st     = ST_EXEC;
                    c_d.launch = 1'b1;
                end
            end
            ST_EXEC: begin
                if (cmd_wr_i) c_d.err = 1'b1;
                if (eng_done_i) begin
                    c_d.st    = ST_IDLE;
                    c_d.ready = 1'b1;
                    c_d.cmpl  = 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.st    <= ST_IDLE;
            c_q.ready <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign ready_o     = c_q.ready;
    assign err_o       = c_q.err;
    assign waiting_o   = (c_q.st == ST_WAIT);
    assign executing_o = (c_q.st == ST_EXEC);
    assign launch_o    = c_q.launch;
    assign cmpl_o      = c_q.cmpl;
    assign code_o      = c_q.code;
endmodule

// File: rtl/fcs_irq_gen.sv
module fcs_irq_gen #(
    parameter int               CMD_W    = 6,
    parameter logic [CMD_W-1:0] QPR_CODE = 6'h0C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr_i,
    input  logic             ctrl_irq_en_i,
    input  logic             ready_i,
    input  logic             cmpl_i,
    input  logic [CMD_W-1:0] code_i,
    output logic             irq_o
);
    typedef struct packed {
        logic en;
    } ctl_t;

    ctl_t k_d, k_q;

    always_comb begin
        k_d = k_q;
        if (ctrl_wr_i) k_d.en = ctrl_irq_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    assign irq_o = ready_i & cmpl_i & k_q.en & (code_i != QPR_CODE);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int               CMD_W       = 6,
    parameter logic [CMD_W-1:0] QPR_CODE    = 6'h0C,
    parameter int               EXEC_CYCLES = 8,
    localparam int              STAT_W      = STAT_CODE_LSB + CMD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_i,
    input  logic [CMD_W-1:0]  cmd_code_i,
    input  logic              ctrl_wr_i,
    input  logic              ctrl_irq_en_i,
    input  logic              stat_rd_i,
    input  logic              bus_idle_i,
    output logic              ready_o,
    output logic              irq_o,
    output logic [STAT_W-1:0] stat_o,
    output logic              launch_o,
    output logic [CMD_W-1:0]  launch_code_o
);
    logic             eng_done;
    logic             err, waiting, executing, cmpl;
    logic [CMD_W-1:0] code;

    fcs_seq_core #(.CMD_W(CMD_W)) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr_i    (cmd_wr_i),
        .cmd_code_i  (cmd_code_i),
        .stat_rd_i   (stat_rd_i),
        .bus_idle_i  (bus_idle_i),
        .eng_done_i  (eng_done),
        .ready_o     (ready_o),
        .err_o       (err),
        .waiting_o   (waiting),
        .executing_o (executing),
        .launch_o    (launch_o),
        .cmpl_o      (cmpl),
        .code_o      (code)
    );

    fcs_exec_stub #(.EXEC_CYCLES(EXEC_CYCLES)) stub_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (launch_o),
        .done_o  (eng_done)
    );

    fcs_irq_gen #(.CMD_W(CMD_W), .QPR_CODE(QPR_CODE)) irq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_wr_i     (ctrl_wr_i),
        .ctrl_irq_en_i (ctrl_irq_en_i),
        .ready_i       (ready_o),
        .cmpl_i        (cmpl),
        .code_i        (code),
        .irq_o         (irq_o)
    );

    always_comb begin
        stat_o                          = '0;
        stat_o[STAT_READY_BIT]          = ready_o;
        stat_o[STAT_ERR_BIT]            = err;
        stat_o[STAT_WAIT_BIT]           = waiting;
        stat_o[STAT_EXEC_BIT]           = executing;
        stat_o[STAT_CODE_LSB +: CMD_W]  = code;
    end

    assign launch_code_o = code;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
    import fcs_pkg::*;
#(
    parameter int               CMD_W    = 6,
    parameter logic [CMD_W-1:0] QPR_CODE = 6'h0C,
    localparam int              STAT_W   = STAT_CODE_LSB + CMD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr_i,
    input logic              bus_idle_i,
    input logic              ready_o,
    input logic              irq_o,
    input logic [STAT_W-1:0] stat_o,
    input logic              launch_o
);
    AST_LAUNCH_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |-> $past(bus_idle_i)) else $error("launch without idle bus"); // R3
    AST_LAUNCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> !launch_o) else $error("launch longer than one cycle"); // R3
    AST_NO_LAUNCH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |-> !ready_o) else $error("launch while ready"); // R3
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && ready_o) |=> !ready_o) else $error("ready kept after write"); // R2
    AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ready_o) else $error("irq while busy"); // R8
    AST_QPR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stat_o[STAT_CODE_LSB +: CMD_W] != QPR_CODE)) else $error("irq for quick read"); // R9
    AST_BUSY_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && !ready_o) |=> stat_o[STAT_ERR_BIT]) else $error("busy write not flagged"); // R6
    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && ready_o) |=> !irq_o) else $error("irq kept after write"); // R10
endmodule

bind flash_cmd_seq fcs_checker #(.CMD_W(CMD_W), .QPR_CODE(QPR_CODE)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr_i   (cmd_wr_i),
    .bus_idle_i (bus_idle_i),
    .ready_o    (ready_o),
    .irq_o      (irq_o),
    .stat_o     (stat_o),
    .launch_o   (launch_o)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb_top;
    localparam int         CMD_W = 6;
    localparam int         N     = 8;
    localparam logic [5:0] QPR   = 6'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [5:0]  cmd_code = '0;
    logic        ctrl_wr = 1'b0;
    logic        ctrl_en = 1'b0;
    logic        stat_rd = 1'b0;
    logic        bus_idle = 1'b1;
    logic        ready, irq, launch;
    logic [13:0] stat;
    logic [5:0]  launch_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit en_m   = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_seq #(.CMD_W(CMD_W), .QPR_CODE(QPR), .EXEC_CYCLES(N)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_wr_i      (cmd_wr),
        .cmd_code_i    (cmd_code),
        .ctrl_wr_i     (ctrl_wr),
        .ctrl_irq_en_i (ctrl_en),
        .stat_rd_i     (stat_rd),
        .bus_idle_i    (bus_idle),
        .ready_o       (ready),
        .irq_o         (irq),
        .stat_o        (stat),
        .launch_o      (launch),
        .launch_code_o (launch_code)
    );

    function automatic bit exp_irq(bit en, logic [5:0] code);
        return en && (code != QPR);
    endfunction

    function automatic int exp_latency();
        return N + 2;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_en(bit v);
        ctrl_wr = 1'b1; ctrl_en = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
        en_m = v;
    endtask

    task automatic run_cmd(logic [5:0] code, int busy, bit inject);
        int launches;
        int cnt;
        chk(ready == 1'b1, "R2 ready before write", int'(ready), 1);
        cmd_wr = 1'b1; cmd_code = code; bus_idle = 1'b0;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(ready == 1'b0, "R2 ready low after write", int'(ready), 0);
        chk(stat[13:8] == code, "R2 code latched", int'(stat[13:8]), int'(code));
        chk(irq == 1'b0, "R10 irq dropped", int'(irq), 0);
        launches = 0;
        for (int k = 1; k <= busy + 1; k++) begin
            bus_idle = (k > busy);
            @(negedge clk);
            if (k <= busy) begin
                chk(launch == 1'b0, "R3 no launch while busy", int'(launch), 0);
                chk(stat[3:0] == 4'b0100, "R5 waiting status", int'(stat[3:0]), 4);
            end
            if (launch) launches++;
        end
        chk(launch == 1'b1, "R3 launch at idle", int'(launch), 1);
        chk(launch_code == code, "R3 launch code", int'(launch_code), int'(code));
        cnt = 0;
        while (!ready && cnt < 50) begin
            bus_idle = 1'($urandom_range(0, 1));
            if (inject && cnt == 2) begin
                cmd_wr = 1'b1; cmd_code = ~code;
            end
            @(negedge clk);
            cmd_wr = 1'b0;
            cnt++;
            if (launch) launches++;
            if (!ready) chk(stat[3] == 1'b1, "R5 executing status", int'(stat[3:0]), 8);
        end
        bus_idle = 1'b1;
        chk(cnt == exp_latency(), "R4 completion latency", cnt, exp_latency());
        chk(launches == 1, "R6 single launch", launches, 1);
        chk(stat[13:8] == code, "R6 code unchanged", int'(stat[13:8]), int'(code));
        chk(irq == exp_irq(en_m, code), "R8 R9 irq at completion", int'(irq), int'(exp_irq(en_m, code)));
        chk(stat[7:4] == 4'b0, "R5 reserved bits", int'(stat[7:4]), 0);
        chk(stat[1] == inject, "R6 error bit", int'(stat[1]), int'(inject));
        if (inject) begin
            stat_rd = 1'b1;
            @(negedge clk);
            stat_rd = 1'b0;
            chk(stat[1] == 1'b0, "R7 read clears error", int'(stat[1]), 0);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(negedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5EED1));
        repeat (3) @(negedge clk);
        chk(ready == 1'b1, "R1 reset ready", int'(ready), 1);
        chk(irq == 1'b0, "R1 reset irq", int'(irq), 0);
        chk(stat == 14'h0001, "R1 reset status", int'(stat), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(launch == 1'b0, "R1 no launch", int'(launch), 0);

        // directed: enabled non-QPR completion, then enable toggling
        set_en(1'b1);
        run_cmd(6'h01, 0, 1'b0);
        set_en(1'b0);
        chk(irq == 1'b0, "R11 clear enable drops irq", int'(irq), 0);
        set_en(1'b1);
        chk(irq == 1'b1, "R11 set enable raises irq", int'(irq), 1);

        // directed: QPR with enable set never interrupts
        run_cmd(QPR, 3, 1'b0);
        chk(irq == 1'b0, "R9 quick read silent", int'(irq), 0);
        set_en(1'b1);
        chk(irq == 1'b0, "R9 enable rewrite after quick read", int'(irq), 0);

        // directed: busy write in same cycle as status read keeps error set
        cmd_wr = 1'b1; cmd_code = 6'h05;
        @(negedge clk);
        cmd_wr = 1'b1; cmd_code = 6'h06; stat_rd = 1'b1; bus_idle = 1'b0;
        @(negedge clk);
        cmd_wr = 1'b0; stat_rd = 1'b0; bus_idle = 1'b1;
        chk(stat[1] == 1'b1, "R7 set wins over read", int'(stat[1]), 1);
        chk(stat[13:8] == 6'h05, "R6 busy write ignored", int'(stat[13:8]), 5);
        while (!ready) @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk(stat[1] == 1'b0, "R7 error cleared", int'(stat[1]), 0);

        // random mix
        for (int i = 0; i < 40; i++) begin
            logic [5:0] c;
            c = ($urandom_range(0, 3) == 0) ? QPR : 6'($urandom_range(0, 63));
            if ($urandom_range(0, 2) == 0) set_en(1'($urandom_range(0, 1)));
            run_cmd(c, int'($urandom_range(0, 5)), 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule